// File: doc/BRIEF.md
# Serial-Loaded March Command Sequencer

This block lets a tester run a march-style memory test that is chosen at run time. The tester does not need a fixed algorithm in silicon. It shifts a program into the block one bit per enabled clock. Each program word is 5 bits wide and describes one march element: an operation code, a data-background bit and an address-direction bit. A load-done pulse seals the program. A start pulse then runs the stored words in order against a simple flash operation port that supports read, program and whole-array erase.

The sequencer walks every address for each element. It carries out all the element's steps at one address before it moves to the next address. During each read it compares the returned word with the value the element expects. The first mismatch sets a sticky error flag and records the address where it happened. A done flag rises when the program ends, and the sealed program can be started again without loading it a second time.

Top module: `shift_cmd_interp`

## Requirements
- R1: Command words are shifted in least significant bit first, one bit per cycle with `shift_en` high. In a 5-bit word, bits 4..2 are the operation code, bit 1 is the background bit and bit 0 is the direction bit.
- R2: The buffer stores at most DEPTH (16) words. A complete word arriving when the buffer is full is dropped and `overflow` is set. The first shifted bit of a new load clears `overflow`.
- R3: After `start`, the words run in load order. Running stops at the first word whose code is 0 or 7, or after the last stored word. `done` is then high and `op_req` is low.
- R4: Code 1 issues one erase operation (`op_kind`=2) at address 0. Its direction bit has no effect.
- R5: The other codes issue steps at each address: code 2 issues r1; code 3 issues p0; code 4 issues r1,p0,r0; code 5 issues r1,p0,r0,r0; code 6 issues r0,p0. Reads use `op_kind`=0 and programs use `op_kind`=1.
- R6: Direction bit 0 walks addresses from 0 up to 2^AW-1. Direction bit 1 walks them from 2^AW-1 down to 0.
- R7: When the background bit is 1, every step value is inverted. The step value is replicated on `op_data`, which carries the program data for a program and the expected word for a read.
- R8: A read whose `op_rdata` differs from `op_data` sets `err` and captures its address in `err_addr`. Later mismatches leave `err_addr` unchanged. `start` clears both.
- R9: `shift_en` and `start` are ignored while a program runs. `start` is ignored until `load_done` has sealed a load.
- R10: `op_req` stays high until a cycle with `op_ack` high. `op_kind`, `op_addr` and `op_data` hold steady while `op_req` is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial command bit |
| shift_en | input | 1 | Takes `ser_in` this cycle |
| load_done | input | 1 | Seals the loaded program |
| start | input | 1 | Runs the sealed program |
| op_req | output | 1 | Flash operation request |
| op_kind | output | 2 | 0 read, 1 program, 2 erase |
| op_addr | output | AW | Operation address |
| op_data | output | DW | Program data or expected read word |
| op_ack | input | 1 | Operation complete; `op_rdata` valid |
| op_rdata | input | DW | Read word |
| err | output | 1 | Sticky read mismatch |
| err_addr | output | AW | Address of first mismatch |
| done | output | 1 | Program finished |
| overflow | output | 1 | Command words were dropped |

## Verification
The hardest case to reach is a read mismatch on a descending walk at an address that is not the first one visited. Getting there needs an erase, a program pass and a background-inverted read, and the array must actually hold a faulty cell. The bench's flash model forces one bit at address 5 to stick at one and runs that three-word program. It then expects `err_addr` to be 5 and not 7. Overflow is reached by shifting seventeen words, and the bench confirms that only sixteen run.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam int CMD_W = 5;

    localparam logic [2:0] C_END  = 3'd0;
    localparam logic [2:0] C_ERS  = 3'd1;
    localparam logic [2:0] C_RD   = 3'd2;
    localparam logic [2:0] C_PG   = 3'd3;
    localparam logic [2:0] C_RPR  = 3'd4;
    localparam logic [2:0] C_RPRR = 3'd5;
    localparam logic [2:0] C_RP   = 3'd6;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READY,
        S_SETUP,
        S_ISSUE,
        S_DONE
    } st_e;

    // number of steps per address for an element code
    function automatic logic [2:0] elem_len(input logic [2:0] code);
        case (code)
            C_RPR:   return 3'd3;
            C_RPRR:  return 3'd4;
            C_RP:    return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    // step is a program (otherwise a read)
    function automatic logic step_prog(input logic [2:0] code, input logic [2:0] step);
        return (code == C_PG) || ((code >= C_RPR) && (code <= C_RP) && (step == 3'd1));
    endfunction

    // value before background inversion
    function automatic logic step_val(input logic [2:0] code, input logic [2:0] step);
        return (code == C_RD) || (((code == C_RPR) || (code == C_RPRR)) && (step == 3'd0));
    endfunction

endpackage

// File: rtl/sci_loader.sv
module sci_loader #(
    parameter int DEPTH = 16,
    localparam int CW = sci_pkg::CMD_W,
    localparam int IW = $clog2(DEPTH),
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          shift_i,
    input  logic          ser_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [CW-1:0] rd_cmd_o,
    output logic [PW-1:0] cnt_o,
    output logic          ovf_o
);

    typedef struct packed {
        logic [DEPTH-1:0][CW-1:0] mem;
        logic [CW-2:0]            sh;
        logic [2:0]               bits;
        logic [PW-1:0]            cnt;
        logic                     ovf;
    } ld_t;

    ld_t ld_d, ld_q;

    always_comb begin
        ld_d = ld_q;
        if (clear_i) begin
            ld_d.bits = '0;
            ld_d.cnt  = '0;
            ld_d.ovf  = 1'b0;
        end
        if (shift_i) begin
            if (ld_d.bits == 3'(CW - 1)) begin
                ld_d.bits = '0;
                if (ld_d.cnt < PW'(DEPTH)) begin
                    ld_d.mem[ld_d.cnt[IW-1:0]] = {ser_i, ld_d.sh};
                    ld_d.cnt = ld_d.cnt + PW'(1);
                end else begin
                    ld_d.ovf = 1'b1;
                end
            end else begin
                ld_d.sh   = {ser_i, ld_d.sh[CW-2:1]};
                ld_d.bits = ld_d.bits + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= ld_d;
    end

    assign rd_cmd_o = (rd_idx_i < PW'(DEPTH)) ? ld_q.mem[rd_idx_i[IW-1:0]] : '0;
    assign cnt_o    = ld_q.cnt;
    assign ovf_o    = ld_q.ovf;

    p_ovf_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (cnt_o == PW'(DEPTH)));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i && !clear_i && (cnt_o == PW'(DEPTH)) |=> (cnt_o == PW'(DEPTH)));

endmodule

// File: rtl/sci_exec.sv
module sci_exec
    import sci_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 4,
    parameter int DEPTH = 16,
    localparam int CW = sci_pkg::CMD_W,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          load_done,
    input  logic          start,
    input  logic [CW-1:0] cmd_i,
    input  logic [PW-1:0] cnt_i,
    output logic [PW-1:0] pc_o,
    output logic          accept_o,
    output logic          clear_o,
    output logic          op_req,
    output logic [1:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    input  logic          op_ack,
    input  logic [DW-1:0] op_rdata,
    output logic          err,
    output logic [AW-1:0] err_addr,
    output logic          done
);

    typedef struct packed {
        st_e           st;
        logic [PW-1:0] pc;
        logic [AW-1:0] addr;
        logic [2:0]    step;
        logic          err;
        logic [AW-1:0] eaddr;
    } ex_t;

    ex_t ex_d, ex_q;

    logic [2:0] code;
    logic       bg, dsc, is_prog, last_step, last_addr, rest;
    op_e        kind;

    always_comb begin
        code      = cmd_i[4:2];
        bg        = cmd_i[1];
        dsc       = cmd_i[0];
        is_prog   = step_prog(code, ex_q.step);
        kind      = (code == C_ERS) ? OP_ERASE : (is_prog ? OP_PROG : OP_READ);
        last_step = (ex_q.step == elem_len(code) - 3'd1);
        last_addr = dsc ? (ex_q.addr == '0) : (ex_q.addr == '1);
        rest      = (ex_q.st == S_READY) || (ex_q.st == S_DONE);

        op_req   = (ex_q.st == S_ISSUE);
        op_kind  = kind;
        op_addr  = ex_q.addr;
        op_data  = {DW{step_val(code, ex_q.step) ^ bg}};
        accept_o = (ex_q.st == S_IDLE) || (rest && !start);
        clear_o  = rest && shift_en && !start;

        ex_d = ex_q;
        case (ex_q.st)
            S_IDLE: if (load_done) ex_d.st = S_READY;
            S_READY, S_DONE: begin
                if (start) begin
                    ex_d.st    = S_SETUP;
                    ex_d.pc    = '0;
                    ex_d.err   = 1'b0;
                    ex_d.eaddr = '0;
                end else if (shift_en) begin
                    ex_d.st = S_IDLE;
                end
            end
            S_SETUP: begin
                if ((ex_q.pc == cnt_i) || (code == C_END) || (code == 3'd7)) begin
                    ex_d.st = S_DONE;
                end else begin
                    ex_d.st   = S_ISSUE;
                    ex_d.step = '0;
                    ex_d.addr = (code != C_ERS && dsc) ? '1 : '0;
                end
            end
            S_ISSUE: if (op_ack) begin
                if (kind == OP_READ && op_rdata != op_data && !ex_q.err) begin
                    ex_d.err   = 1'b1;
                    ex_d.eaddr = ex_q.addr;
                end
                if (code == C_ERS) begin
                    ex_d.pc = ex_q.pc + PW'(1);
                    ex_d.st = S_SETUP;
                end else if (!last_step) begin
                    ex_d.step = ex_q.step + 3'd1;
                end else begin
                    ex_d.step = '0;
                    if (last_addr) begin
                        ex_d.pc = ex_q.pc + PW'(1);
                        ex_d.st = S_SETUP;
                    end else begin
                        ex_d.addr = dsc ? ex_q.addr - AW'(1) : ex_q.addr + AW'(1);
                    end
                end
            end
            default: ex_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ex_q <= '{st: S_IDLE, default: '0};
        else        ex_q <= ex_d;
    end

    assign pc_o     = ex_q.pc;
    assign err      = ex_q.err;
    assign err_addr = ex_q.eaddr;
    assign done     = (ex_q.st == S_DONE);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_req && !op_ack |=> op_req && $stable(op_addr) && $stable(op_kind) && $stable(op_data));

    p_erase_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_req && (op_kind == 2'd2) |-> (op_addr == '0));

    p_done_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !op_req);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err && !start |=> err && $stable(err_addr));

endmodule

// File: rtl/shift_cmd_interp.sv
module shift_cmd_interp #(
    parameter int AW = 3,
    parameter int DW = 4,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    input  logic          shift_en,
    input  logic          load_done,
    input  logic          start,
    output logic          op_req,
    output logic [1:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    input  logic          op_ack,
    input  logic [DW-1:0] op_rdata,
    output logic          err,
    output logic [AW-1:0] err_addr,
    output logic          done,
    output logic          overflow
);

    localparam int CW = sci_pkg::CMD_W;
    localparam int PW = $clog2(DEPTH + 1);

    logic [CW-1:0] cmd;
    logic [PW-1:0] cnt, pc;
    logic          accept, clear;

    sci_loader #(.DEPTH(DEPTH)) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .shift_i  (shift_en && accept),
        .ser_i    (ser_in),
        .rd_idx_i (pc),
        .rd_cmd_o (cmd),
        .cnt_o    (cnt),
        .ovf_o    (overflow)
    );

    sci_exec #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .load_done (load_done),
        .start     (start),
        .cmd_i     (cmd),
        .cnt_i     (cnt),
        .pc_o      (pc),
        .accept_o  (accept),
        .clear_o   (clear),
        .op_req    (op_req),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .op_ack    (op_ack),
        .op_rdata  (op_rdata),
        .err       (err),
        .err_addr  (err_addr),
        .done      (done)
    );

endmodule

// File: tb/tb_shift_cmd_interp.sv
module tb_shift_cmd_interp;

    localparam int AW = 3;
    localparam int DW = 4;
    localparam int N  = 1 << AW;

    logic clk = 0, rst_n = 0;
    logic ser_in = 0, shift_en = 0, load_done = 0, start = 0;
    logic op_req, op_ack = 0, err, done, overflow;
    logic [1:0] op_kind;
    logic [AW-1:0] op_addr, err_addr;
    logic [DW-1:0] op_data, op_rdata = '0;

    shift_cmd_interp dut (.*);

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    logic [DW-1:0] mem [N];
    bit stuck_en = 0;
    logic [4:0] prog [32];
    int prog_n;
    int exp_kind [1024];
    int exp_addr [1024];
    logic [DW-1:0] exp_dat [1024];
    int exp_n, got_n;
    bit e_err;
    int e_eaddr;
    bit req_seen;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [4:0] C(input int code, input int bg, input int dir);
        return {3'(code), 1'(bg), 1'(dir)};
    endfunction

    function automatic void push(input int k, input int a, input logic [DW-1:0] d);
        exp_kind[exp_n] = k; exp_addr[exp_n] = a; exp_dat[exp_n] = d; exp_n++;
    endfunction

    // reference trace computed from the requirement text (R3..R7)
    function automatic void build();
        exp_n = 0;
        for (int i = 0; i < prog_n && i < 16; i++) begin
            int code = int'(prog[i][4:2]);
            int bg   = int'(prog[i][1]);
            int n;
            int pk [4];
            int vl [4];
            if (code == 0 || code == 7) break;
            if (code == 1) begin push(2, 0, '0); continue; end
            case (code)
                2: begin n = 1; pk = '{0,0,0,0}; vl = '{1,0,0,0}; end
                3: begin n = 1; pk = '{1,0,0,0}; vl = '{0,0,0,0}; end
                4: begin n = 3; pk = '{0,1,0,0}; vl = '{1,0,0,0}; end
                5: begin n = 4; pk = '{0,1,0,0}; vl = '{1,0,0,0}; end
                default: begin n = 2; pk = '{0,1,0,0}; vl = '{0,0,0,0}; end
            endcase
            for (int k = 0; k < N; k++) begin
                int a = prog[i][0] ? N - 1 - k : k;
                for (int s = 0; s < n; s++)
                    push(pk[s], a, (vl[s] ^ bg) ? {DW{1'b1}} : {DW{1'b0}});
            end
        end
    endfunction

    task automatic load(input bit seal);
        for (int i = 0; i < prog_n; i++)
            for (int b = 0; b < 5; b++) begin
                @(negedge clk); shift_en = 1; ser_in = prog[i][b];
            end
        @(negedge clk); shift_en = 0; ser_in = 0;
        if (seal) begin
            load_done = 1; @(negedge clk); load_done = 0;
        end
    endtask

    // runs the sealed program with a flash model; noise pokes shift/start mid-run
    task automatic run(input bit noise);
        int cyc = 0;
        got_n = 0; e_err = 0; e_eaddr = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        while (cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (noise) begin
                shift_en = (cyc >= 3 && cyc < 9);
                ser_in   = 1;
                start    = (cyc == 6);
            end
            if (op_ack) begin
                op_ack = 0;
            end else if (op_req) begin
                if (got_n < exp_n) begin
                    check(int'(op_kind) == exp_kind[got_n], "R5 op kind", int'(op_kind), exp_kind[got_n]);
                    check(int'(op_addr) == exp_addr[got_n], "R6 op addr", int'(op_addr), exp_addr[got_n]);
                    if (op_kind != 2'd2)
                        check(op_data == exp_dat[got_n], "R7 op data", int'(op_data), int'(exp_dat[got_n]));
                end
                if (op_kind == 2'd2) begin
                    for (int a = 0; a < N; a++) mem[a] = '1;
                end else if (op_kind == 2'd1) begin
                    mem[op_addr] = op_data;
                end else begin
                    op_rdata = mem[op_addr] | ((stuck_en && op_addr == 5) ? 4'b0100 : 4'b0000);
                    if (got_n < exp_n && op_rdata != exp_dat[got_n] && !e_err) begin
                        e_err = 1; e_eaddr = int'(op_addr);
                    end
                end
                got_n++;
                op_ack = 1;
            end else if (done && cyc > 10) begin
                break;
            end
        end
        shift_en = 0; start = 0;
        check(done == 1'b1 && !op_req, "R3 done", int'(done), 1);
        check(got_n == exp_n, "R3 op count", got_n, exp_n);
        check(err == e_err, "R8 err", int'(err), int'(e_err));
        if (e_err) check(int'(err_addr) == e_eaddr, "R8 err_addr", int'(err_addr), e_eaddr);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < N; a++) mem[a] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!op_req && !done && !err && !overflow, "R3 reset state", int'({op_req, done, err, overflow}), 0);

        // R1/R6 MSCAN style: descending, last read finds zeros at address 7 first
        prog_n = 4;
        prog[0] = C(1,0,1); prog[1] = C(2,0,1); prog[2] = C(3,0,1); prog[3] = C(2,0,1);
        load(1); build(); run(0);
        check(int'(err_addr) == 7, "R6 first fail on descending walk", int'(err_addr), 7);

        // R5 March-FD style, fault free
        prog_n = 8;
        prog[0] = C(1,0,0); prog[1] = C(2,0,0); prog[2] = C(4,0,0); prog[3] = C(1,0,0);
        prog[4] = C(2,0,0); prog[5] = C(5,0,1); prog[6] = C(6,0,0); prog[7] = C(2,1,0);
        load(1); build(); run(0);
        check(exp_n == 98 && err == 0, "R5 march trace length", got_n, 98);

        // R7 background: program ones, read expecting zeros fails at 0
        prog_n = 3;
        prog[0] = C(1,0,0); prog[1] = C(3,1,0); prog[2] = C(2,1,0);
        load(1); build(); run(0);
        check(err && err_addr == 0, "R7 inverted read mismatch", int'(err_addr), 0);

        // R8 stuck bit at address 5, descending read
        stuck_en = 1;
        prog_n = 3;
        prog[0] = C(1,0,1); prog[1] = C(3,0,0); prog[2] = C(2,1,1);
        load(1); build(); run(0);
        check(int'(err_addr) == 5, "R8 stuck cell address", int'(err_addr), 5);
        stuck_en = 0;

        // R2 overflow: 17 words, the last dropped
        prog_n = 17;
        prog[0] = C(1,0,0);
        for (int i = 1; i < 17; i++) prog[i] = C(2,0,1);
        load(1);
        check(overflow == 1'b1, "R2 overflow set", int'(overflow), 1);
        build(); run(0);
        check(got_n == 121, "R2 sixteen words run", got_n, 121);

        // R3 end codes; R2 overflow cleared by new load
        prog_n = 3;
        prog[0] = C(1,0,0); prog[1] = C(0,0,0); prog[2] = C(2,0,0);
        load(1);
        check(overflow == 1'b0, "R2 overflow cleared", int'(overflow), 0);
        build(); run(0);
        check(got_n == 1, "R3 code 0 ends", got_n, 1);
        prog_n = 2;
        prog[0] = C(7,1,1); prog[1] = C(1,0,0);
        load(1); build(); run(0);
        check(got_n == 0, "R3 code 7 ends", got_n, 0);

        // R9 start before seal ignored
        prog_n = 2;
        prog[0] = C(1,0,1); prog[1] = C(2,0,0);
        load(0);
        req_seen = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (op_req || done) req_seen = 1;
        end
        check(!req_seen, "R9 start before seal", int'(req_seen), 0);
        @(negedge clk); load_done = 1; @(negedge clk); load_done = 0;

        // R9 shift/start noise during run ignored; rerun without reload
        build(); run(1);
        check(got_n == 9, "R9 noisy run count", got_n, 9);
        run(0);
        check(got_n == 9 && overflow == 0, "R9 program kept after noise", got_n, 9);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule